// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Rounder

This block takes a 32-bit fixed-point word with 24 integer bits above 8 fraction bits and rounds it to the nearest whole number. A mode input tells the block how to read the word: as an unsigned quantity or as a two's-complement signed quantity. The bits alone cannot tell the two apart, so the caller must supply the mode along with every word.

Both readings go through one datapath. The word is first widened by one bit into a signed value. In unsigned mode the new top bit is zero. In signed mode it copies the old sign bit. That widened range holds every value of either reading.

Half of one unit is then added to the widened value and the fraction is dropped. This rounds to the nearest integer, and exact halves go toward positive infinity. The result is a 26-bit signed integer. It is registered together with a valid flag, one cycle after the input is accepted.

Top module: `fxr_rounder`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous cycle. While `rst_n` is low, `out_valid` and `out_value` are cleared to 0.
- R2: When `in_signed` is 0, `in_word` is read as an unsigned number equal to `in_word`/256, and the result is never negative.
- R3: When `in_signed` is 1, `in_word` is read as a two's-complement number equal to `$signed(in_word)`/256, and the result lies in [-8388608, 8388608].
- R4: The result is floor(x + 1/2), where x is the value of the word. Fraction bits `in_word[7:0]` below 0x80 round down and 0x80 or above round up, so the result never differs from x by more than one half.
- R5: A negative value whose fraction is exactly one half rounds toward positive infinity. For example, signed 0xFFFFFD80 (-2.5) gives -2.
- R6: Unsigned 0xFFFFFFFF gives exactly 16777216 with no wrap, and `out_value` is 26 bits wide so that this result fits.
- R7: In a cycle where `in_valid` is 0, `out_value` keeps its previous value in the next cycle.
- R8: Signed 0x80000000 gives -8388608 and signed 0x7FFFFFFF gives 8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_signed | input | 1 | 1: word is two's-complement; 0: word is unsigned |
| in_word | input | 32 | Fixed-point input, 24 integer bits over 8 fraction bits |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| out_value | output | 26 | Rounded signed integer result |

## Verification
Every fraction code from 0x00 to 0xFF is paired with a set of integer parts and tried in both modes:
- The full fraction sweep places the round-up threshold at 0x80 exactly.
- Integer parts of 0, ±1 and ±2 show whether halves below zero go toward positive infinity rather than away from zero.
- Integer parts with the top bit set give different results in the two modes, so any mix-up between zero-extension and sign-extension shows up.
- The extreme words 0xFFFFFFFF, 0x7FFFFFFF and 0x80000000 expose wrap-around in the widened sum.

Cycles with `in_valid` low and changing data show that the output register holds its value.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
    localparam int FXR_INT_W  = 24;
    localparam int FXR_FRAC_W = 8;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } fxr_mode_e;
endpackage

// File: rtl/fxr_widen.sv
// Widens the input word by one bit into a signed form that holds both readings.
module fxr_widen
    import fxr_pkg::*;
#(
    parameter int IN_W = FXR_INT_W + FXR_FRAC_W
) (
    input  logic [IN_W-1:0]   word,
    input  fxr_mode_e         mode,
    output logic signed [IN_W:0] wide
);
    logic ext_bit;

    always_comb begin
        ext_bit = (mode == MODE_SIGNED) ? word[IN_W-1] : 1'b0;
        wide    = $signed({ext_bit, word});
    end
endmodule

// File: rtl/fxr_round.sv
// Adds one half unit and drops the fraction. The sum carries one guard bit,
// so the largest unsigned input does not wrap.
module fxr_round
    import fxr_pkg::*;
#(
    parameter int IN_W   = FXR_INT_W + FXR_FRAC_W,
    parameter int FRAC_W = FXR_FRAC_W
) (
    input  logic signed [IN_W:0]            wide,
    output logic signed [IN_W-FRAC_W+1:0]   rounded
);
    localparam int SUM_W = IN_W + 2;

    logic signed [SUM_W-1:0] ext;
    logic signed [SUM_W-1:0] half;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        ext  = {wide[IN_W], wide};
        half = '0;
        half[FRAC_W-1] = 1'b1;
        sum  = ext + half;
        rounded = sum[SUM_W-1:FRAC_W];
    end
endmodule

// File: rtl/fxr_rounder.sv
module fxr_rounder
    import fxr_pkg::*;
#(
    parameter int INT_W  = FXR_INT_W,
    parameter int FRAC_W = FXR_FRAC_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_signed,
    input  logic [INT_W+FRAC_W-1:0]       in_word,
    output logic                          out_valid,
    output logic signed [INT_W+1:0]       out_value
);
    localparam int IN_W  = INT_W + FRAC_W;
    localparam int OUT_W = INT_W + 2;
    localparam int CHK_W = IN_W + 2;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] val;
    } state_t;

    state_t state_d, state_q;

    fxr_mode_e                 mode;
    logic signed [IN_W:0]      wide;
    logic signed [OUT_W-1:0]   rounded;

    assign mode = in_signed ? MODE_SIGNED : MODE_UNSIGNED;

    fxr_widen #(.IN_W(IN_W)) u_widen (
        .word (in_word),
        .mode (mode),
        .wide (wide)
    );

    fxr_round #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_round (
        .wide    (wide),
        .rounded (rounded)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.val = rounded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_value = state_q.val;

    // Rounding error between the widened input and the rounded result
    logic signed [CHK_W-1:0] chk_back;
    logic signed [CHK_W-1:0] chk_err;
    assign chk_back = {rounded, {FRAC_W{1'b0}}};
    assign chk_err  = {wide[IN_W], wide} - chk_back;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_value));  // R7
    AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed) |=> !out_value[OUT_W-1]);  // R2
    AST_SIGNED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed) |=> ($signed(out_value) >= -(2**(INT_W-1)) &&
                                     $signed(out_value) <=  (2**(INT_W-1))));  // R3
    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (chk_err >= -(2**(FRAC_W-1)) && chk_err < (2**(FRAC_W-1))));  // R4
endmodule

// File: tb/sim_fxr_rounder.sv
module sim_fxr_rounder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_signed = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic signed [25:0] out_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxr_rounder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_signed (in_signed),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_value (out_value)
    );

    function automatic longint expect_round(input logic sgn, input logic [31:0] w);
        longint x;
        if (sgn) x = longint'($signed(w));
        else     x = longint'({32'd0, w});
        return (x + 128) >>> 8;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive on a falling edge and check at the next falling edge,
    // which comes after exactly one rising edge.
    task automatic apply(input string req, input logic sgn, input logic [31:0] w);
        @(negedge clk);
        in_valid  = 1'b1;
        in_signed = sgn;
        in_word   = w;
        @(negedge clk);
        check(req, longint'(out_valid), 1);
        check(req, longint'($signed(out_value)), expect_round(sgn, w));
        in_valid = 1'b0;
    endtask

    initial begin
        longint held;
        int ipart [10] = '{0, 1, 2, -1, -2, -3, 32'h7FFFFF, -32'sh800000, 32'h123456, 32'hFFFFFF};
        repeat (3) @(negedge clk);
        check("R1 reset valid", longint'(out_valid), 0);
        check("R1 reset value", longint'($signed(out_value)), 0);
        rst_n = 1'b1;

        // R4 R2 R3 sweep of all fraction codes
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 10; i++) begin
                for (int f = 0; f < 256; f++) begin
                    logic [23:0] ip;
                    ip = ipart[i][23:0];
                    apply(m == 1 ? "R3 R4 signed sweep" : "R2 R4 unsigned sweep",
                          logic'(m), {ip, f[7:0]});
                end
            end
        end

        apply("R5 neg half", 1'b1, 32'hFFFFFD80);
        check("R5 value -2", longint'($signed(out_value)), -2);
        apply("R6 all ones", 1'b0, 32'hFFFFFFFF);
        check("R6 value 2^24", longint'($signed(out_value)), 16777216);
        apply("R8 signed min", 1'b1, 32'h80000000);
        check("R8 value min", longint'($signed(out_value)), -8388608);
        apply("R8 signed max", 1'b1, 32'h7FFFFFFF);
        check("R8 value max", longint'($signed(out_value)), 8388608);

        // R7: idle cycles with changing data keep the result
        held = longint'($signed(out_value));
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_signed = logic'(k[0]);
            in_word   = 32'h1357_0000 + 32'(k * 32'h0101_0101);
            @(negedge clk);
            check("R7 hold value", longint'($signed(out_value)), held);
            check("R1 idle valid", longint'(out_valid), 0);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule